// File: doc/BRIEF.md
# Dual-Channel Serial Delay Word Receiver

This block is the receiving end of a three-wire serial link that sets two programmable delay channels. A controller sends a 24-bit frame one bit at a time. Each bit goes on a data line and is taken on the rising edge of a serial clock. A rising edge on a separate latch clock then copies the assembled frame into a transfer register. The transfer register holds a 10-bit delay word for each channel, A and B, and one hold bit for each channel. While a channel's hold bit is clear, that channel's delay output follows the transferred word. While it is set, the output keeps its previous value. The hold bits come in the same frame as the delay words.

All four control wires come from outside the system clock domain. Each one passes through a two-flop synchronizer. Rising edges of the serial clock and the latch clock are detected in the system clock domain. A disable input clears the output-enable flag, which turns off both channel outputs downstream. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `dly_serial_ctrl`

## Requirements
- R1: While reset is asserted, both delay outputs are zero and `out_en_o` is low.
- R2: Each synchronized rising edge of `ser_clk_i` shifts the synchronized `ser_dat_i` into bit 0 of a 24-bit shift register, moving older bits toward bit 23. A frame is therefore sent MSB first, and when more than 24 bits are sent only the last 24 remain.
- R3: Each synchronized rising edge of `lat_clk_i` copies the shift register into the transfer register. Channel A's word is frame bits [9:0] and channel B's word is frame bits [19:10], each with its LSB at the lower bit position.
- R4: Frame bit 20 is channel A's hold bit and frame bit 21 is channel B's hold bit. When a channel's transferred hold bit is 1, that channel's output keeps its value and the other channel is not affected.
- R5: When a channel's transferred hold bit is 0, that channel's output equals its transferred word one system clock after the transfer register changes.
- R6: `out_en_o` is the inverse of the synchronized `out_dis_i`, registered once. Disabling does not change either delay output.
- R7: Frame bits 22 and 23 have no effect on any output.
- R8: With no rising edge of `ser_clk_i`, the shift register does not change, whatever `ser_dat_i` does.
- R9: With no rising edge of `lat_clk_i`, the transfer register and both delay outputs stay as they are, even while new bits are being shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| lat_clk_i | input | 1 | Transfer strobe, asynchronous |
| out_dis_i | input | 1 | Output disable, asynchronous, active high |
| dly_a_o | output | 10 | Channel A delay word |
| dly_b_o | output | 10 | Channel B delay word |
| out_en_o | output | 1 | Output enable flag for both channels |

## Verification
The assertions assume that every level on `ser_clk_i`, `lat_clk_i` and `ser_dat_i` stays stable for at least three system clocks. Under that assumption the synchronizers see each edge exactly once. They also assume that the data line is already settled when the serial clock rises, so the bit taken is the one intended. The stimulus holds each data bit and each clock level for four system clocks. It pulses the latch clock only after the last serial edge has had time to reach the shift register, which keeps the bench inside those assumptions.

// File: rtl/dly_pkg.sv
package dly_pkg;
  localparam int DEF_FRAME_W = 24;
  localparam int DEF_DLY_W   = 10;
  localparam int NUM_CH      = 2;

  // Lowest frame bit of a channel's delay word.
  function automatic int word_lsb(input int ch, input int dly_w);
    return ch * dly_w;
  endfunction

  // Frame position of a channel's hold bit; hold bits follow all words.
  function automatic int hold_pos(input int ch, input int dly_w);
    return NUM_CH * dly_w + ch;
  endfunction
endpackage

// File: rtl/dly_sync.sv
module dly_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/dly_edge_sync.sv
module dly_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic level;
  logic prev_q;
  logic prev_d;

  dly_sync #(.STAGES(STAGES)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(async_i),
    .sync_o (level)
  );

  always_comb begin
    prev_d = level;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= prev_d;
  end

  assign rise_o = level & ~prev_q;
endmodule

// File: rtl/dly_frame_shift.sv
module dly_frame_shift #(
  parameter int WIDTH = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] frame_o
);
  logic [WIDTH-1:0] frame_q;
  logic [WIDTH-1:0] frame_d;

  always_comb begin
    frame_d = frame_q;
    if (shift_en_i) frame_d = {frame_q[WIDTH-2:0], bit_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frame_q <= '0;
    else         frame_q <= frame_d;
  end

  assign frame_o = frame_q;
endmodule

// File: rtl/dly_chan_latch.sv
module dly_chan_latch #(
  parameter int DLY_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic [DLY_W-1:0] word_i,
  output logic [DLY_W-1:0] dly_o
);
  logic [DLY_W-1:0] dly_q;
  logic [DLY_W-1:0] dly_d;
  logic             load_en;

  assign load_en = ~hold_i;

  always_comb begin
    dly_d = dly_q;
    if (load_en) dly_d = word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q <= '0;
    else         dly_q <= dly_d;
  end

  assign dly_o = dly_q;
endmodule

// File: rtl/dly_serial_ctrl.sv
module dly_serial_ctrl
  import dly_pkg::*;
#(
  parameter int FRAME_W     = DEF_FRAME_W,
  parameter int DLY_W       = DEF_DLY_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_dat_i,
  input  logic             ser_clk_i,
  input  logic             lat_clk_i,
  input  logic             out_dis_i,
  output logic [DLY_W-1:0] dly_a_o,
  output logic [DLY_W-1:0] dly_b_o,
  output logic             out_en_o
);
  localparam int USED_W = NUM_CH * (DLY_W + 1);

  // Reset release synchronizer
  logic [1:0] rst_pipe_q;
  logic [1:0] rst_pipe_d;
  logic       rst_n_s;

  always_comb begin
    rst_pipe_d = {rst_pipe_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= rst_pipe_d;
  end

  assign rst_n_s = rst_pipe_q[1];

  // Input synchronization and edge detection
  logic sdat_s;
  logic dis_s;
  logic sclk_rise;
  logic lclk_rise;

  dly_sync #(.STAGES(SYNC_STAGES)) dat_sync_i (
    .clk_i(clk_i), .rst_ni(rst_n_s), .async_i(ser_dat_i), .sync_o(sdat_s)
  );

  dly_sync #(.STAGES(SYNC_STAGES)) dis_sync_i (
    .clk_i(clk_i), .rst_ni(rst_n_s), .async_i(out_dis_i), .sync_o(dis_s)
  );

  dly_edge_sync #(.STAGES(SYNC_STAGES)) sclk_edge_i (
    .clk_i(clk_i), .rst_ni(rst_n_s), .async_i(ser_clk_i), .rise_o(sclk_rise)
  );

  dly_edge_sync #(.STAGES(SYNC_STAGES)) lclk_edge_i (
    .clk_i(clk_i), .rst_ni(rst_n_s), .async_i(lat_clk_i), .rise_o(lclk_rise)
  );

  // Shift stage
  logic [FRAME_W-1:0] shreg_q;

  dly_frame_shift #(.WIDTH(FRAME_W)) shift_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .shift_en_i(sclk_rise),
    .bit_i     (sdat_s),
    .frame_o   (shreg_q)
  );

  // Frame bits above the hold bits carry nothing.
  logic unused_spare;
  assign unused_spare = ^shreg_q[FRAME_W-1:USED_W];

  // Transfer stage
  logic [USED_W-1:0] xfer_q;
  logic [USED_W-1:0] xfer_d;

  always_comb begin
    xfer_d = xfer_q;
    if (lclk_rise) xfer_d = shreg_q[USED_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) xfer_q <= '0;
    else          xfer_q <= xfer_d;
  end

  // Per-channel hold latches
  logic [DLY_W-1:0] chan_dly [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    dly_chan_latch #(.DLY_W(DLY_W)) latch_i (
      .clk_i (clk_i),
      .rst_ni(rst_n_s),
      .hold_i(xfer_q[hold_pos(ch, DLY_W)]),
      .word_i(xfer_q[word_lsb(ch, DLY_W) +: DLY_W]),
      .dly_o (chan_dly[ch])
    );
  end

  assign dly_a_o = chan_dly[0];
  assign dly_b_o = chan_dly[1];

  // Output enable
  logic oe_q;
  logic oe_d;

  always_comb begin
    oe_d = ~dis_s;
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) oe_q <= 1'b0;
    else          oe_q <= oe_d;
  end

  assign out_en_o = oe_q;
endmodule

// File: rtl/dly_serial_ctrl_chk.sv
module dly_serial_ctrl_chk #(
  parameter int FRAME_W = 24,
  parameter int DLY_W   = 10
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          rst_n_s,
  input logic                          sclk_rise,
  input logic                          lclk_rise,
  input logic                          sdat_s,
  input logic                          dis_s,
  input logic [FRAME_W-1:0]            shreg_q,
  input logic [2*(DLY_W+1)-1:0]        xfer_q,
  input logic [DLY_W-1:0]              dly_a_o,
  input logic [DLY_W-1:0]              dly_b_o,
  input logic                          out_en_o
);
  localparam int HOLD_A = 2 * DLY_W;
  localparam int HOLD_B = 2 * DLY_W + 1;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (dly_a_o == '0 && dly_b_o == '0 && !out_en_o)
        else $error("reset state wrong");
    end
  end

  assert_shift_in_R2: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    sclk_rise |=> (shreg_q[0] == $past(sdat_s)) &&
                  (shreg_q[FRAME_W-1:1] == $past(shreg_q[FRAME_W-2:0])));

  assert_no_shift_R8: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !sclk_rise |=> $stable(shreg_q));

  assert_transfer_R3: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    lclk_rise |=> xfer_q == $past(shreg_q[2*(DLY_W+1)-1:0]));

  assert_no_transfer_R9: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !lclk_rise |=> $stable(xfer_q));

  assert_hold_a_R4: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    xfer_q[HOLD_A] |=> $stable(dly_a_o));

  assert_hold_b_R4: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    xfer_q[HOLD_B] |=> $stable(dly_b_o));

  assert_follow_a_R5: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !xfer_q[HOLD_A] |=> dly_a_o == $past(xfer_q[DLY_W-1:0]));

  assert_follow_b_R5: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !xfer_q[HOLD_B] |=> dly_b_o == $past(xfer_q[2*DLY_W-1:DLY_W]));

  assert_disable_R6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    dis_s |=> !out_en_o);

  assert_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !dis_s |=> out_en_o);
endmodule

bind dly_serial_ctrl dly_serial_ctrl_chk #(.FRAME_W(FRAME_W), .DLY_W(DLY_W)) chk_i (.*);

// File: tb/dly_serial_ctrl_tb_top.sv
module dly_serial_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic       clk;
  logic       rst_n;
  logic       sdat;
  logic       sclk;
  logic       lclk;
  logic       dis;
  logic [9:0] dly_a;
  logic [9:0] dly_b;
  logic       oe;

  int checks;
  int errors;
  bit done;

  dly_serial_ctrl dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .ser_dat_i(sdat),
    .ser_clk_i(sclk),
    .lat_clk_i(lclk),
    .out_dis_i(dis),
    .dly_a_o  (dly_a),
    .dly_b_o  (dly_b),
    .out_en_o (oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: wire histories stand in for the input delay.
  bit       h_sclk[$];
  bit       h_lclk[$];
  bit       h_sdat[$];
  bit       h_dis[$];
  int       rel_cnt;
  bit [23:0] m_shift;
  bit [23:0] m_frame;
  int       m_a;
  int       m_b;
  bit       m_oe;

  task automatic model_clear();
    h_sclk = '{0, 0, 0};
    h_lclk = '{0, 0, 0};
    h_sdat = '{0, 0, 0};
    h_dis  = '{0, 0, 0};
    m_shift = '0;
    m_frame = '0;
    m_a = 0;
    m_b = 0;
    m_oe = 0;
  endtask

  initial model_clear();

  always @(posedge clk) begin
    if (!rst_n) rel_cnt = 0;
    else if (rel_cnt < 3) rel_cnt++;
    if (rel_cnt < 3) begin
      model_clear();
    end else begin
      bit s_edge;
      bit l_edge;
      s_edge = h_sclk[1] && !h_sclk[2];
      l_edge = h_lclk[1] && !h_lclk[2];
      if (!m_frame[20]) m_a = int'(m_frame[9:0]);
      if (!m_frame[21]) m_b = int'(m_frame[19:10]);
      if (l_edge) m_frame = m_shift;
      if (s_edge) m_shift = {m_shift[22:0], h_sdat[1]};
      m_oe = !h_dis[1];
      h_sclk.push_front(sclk); void'(h_sclk.pop_back());
      h_lclk.push_front(lclk); void'(h_lclk.pop_back());
      h_sdat.push_front(sdat); void'(h_sdat.pop_back());
      h_dis.push_front(dis);   void'(h_dis.pop_back());
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check("R5 model A", int'(dly_a), m_a);
      check("R5 model B", int'(dly_b), m_b);
      check("R6 model oe", int'(oe), int'(m_oe));
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input bit [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = bits[i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
  endtask

  task automatic latch_pulse();
    lclk = 1'b1;
    wait_clk(HALF);
    lclk = 1'b0;
    wait_clk(6);
  endtask

  function automatic bit [23:0] mk(input bit [9:0] a, input bit [9:0] b,
                                   input bit ha, input bit hb, input bit [1:0] sp);
    return {sp, hb, ha, b, a};
  endfunction

  task automatic send(input bit [23:0] f);
    shift_bits({8'h0, f}, 24);
    latch_pulse();
  endtask

  initial begin
    done = 0;
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    sdat = 1'b0;
    sclk = 1'b0;
    lclk = 1'b0;
    dis  = 1'b1;
    wait_clk(5);
    check("R1 reset A", int'(dly_a), 0);
    check("R1 reset B", int'(dly_b), 0);
    check("R1 reset oe", int'(oe), 0);
    rst_n = 1'b1;
    wait_clk(6);
    check("R6 disabled after reset", int'(oe), 0);
    dis = 1'b0;
    wait_clk(5);
    check("R6 enable", int'(oe), 1);

    send(mk(10'h155, 10'h2AA, 0, 0, 2'b00));
    check("R3 word A", int'(dly_a), 'h155);
    check("R3 word B", int'(dly_b), 'h2AA);

    shift_bits({8'h0, mk(10'h0F0, 10'h00F, 0, 0, 2'b00)}, 24);
    check("R9 no latch A", int'(dly_a), 'h155);
    check("R9 no latch B", int'(dly_b), 'h2AA);
    latch_pulse();
    check("R5 follow A", int'(dly_a), 'h0F0);
    check("R5 follow B", int'(dly_b), 'h00F);

    send(mk(10'h3FF, 10'h3FF, 1, 0, 2'b00));
    check("R4 hold A", int'(dly_a), 'h0F0);
    check("R4 B unaffected", int'(dly_b), 'h3FF);

    send(mk(10'h001, 10'h200, 0, 1, 2'b00));
    check("R4 A unaffected", int'(dly_a), 'h001);
    check("R4 hold B", int'(dly_b), 'h3FF);

    send(mk(10'h123, 10'h321, 0, 0, 2'b11));
    check("R7 spare bits A", int'(dly_a), 'h123);
    check("R7 spare bits B", int'(dly_b), 'h321);

    shift_bits({6'h0, 2'b10, mk(10'h2C3, 10'h11D, 0, 0, 2'b00)}, 26);
    latch_pulse();
    check("R2 long frame A", int'(dly_a), 'h2C3);
    check("R2 long frame B", int'(dly_b), 'h11D);

    shift_bits({8'h0, mk(10'h3A5, 10'h05A, 0, 0, 2'b00)}, 24);
    for (int k = 0; k < 6; k++) begin
      sdat = ~sdat;
      wait_clk(3);
    end
    latch_pulse();
    check("R8 data without clock A", int'(dly_a), 'h3A5);
    check("R8 data without clock B", int'(dly_b), 'h05A);

    send(mk(10'h000, 10'h000, 0, 0, 2'b00));
    check("R3 zero A", int'(dly_a), 0);
    check("R3 zero B", int'(dly_b), 0);

    send(mk(10'h3FF, 10'h155, 0, 0, 2'b00));
    dis = 1'b1;
    wait_clk(5);
    check("R6 disable oe", int'(oe), 0);
    check("R6 disable keeps A", int'(dly_a), 'h3FF);
    check("R6 disable keeps B", int'(dly_b), 'h155);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule